// File: doc/BRIEF.md
# Converter Serial Output Interface

This block is the digital readout port of a single sampling converter, modelled at the logic level and run from a fast system clock. A host starts a conversion by raising the convert line while holding the select line high. That puts the port in chip-select mode, with the data pin released. An internal timer marks the conversion complete a fixed number of clocks later. From then on, while convert stays high, the host lowers select to read the 16-bit result. The most significant bit is presented first, and each falling edge of the serial clock moves the pin to the next lower bit.

The data pin is released after the last bit has been shifted out, or as soon as select rises, whichever comes first. This lets several converters share one data line, each addressed by its own select line. When convert and select are both low, the pin is driven low. All three control inputs are sampled and edge-detected in the system clock domain. Tri-state is represented by an output-enable next to the data bit.

Top module: `conv_serial_port`

## Requirements
- R1: After reset, with convert low and select high, the output enable is low.
- R2: A convert rising edge sampled while select is high selects chip-select mode, and the output enable is low in the cycle after that edge for as long as convert stays high.
- R3: The conversion completes CONV_CYCLES clocks after the sampled convert rising edge. A select falling edge before completion does not enable the output, and select held low across completion leaves the output disabled.
- R4: After completion, a select falling edge sampled while convert is high latches result_i and, one clock later, drives the output with bit 15 of the latched value. A later change of result_i does not alter the word being read.
- R5: Each falling serial-clock edge sampled while the output is driven advances the output to the next lower bit, one clock later. A rising serial-clock edge changes nothing.
- R6: The output enable drops one clock after the 16th falling serial-clock edge of a read.
- R7: Raising select releases the output at once, even partway through a read.
- R8: Every select falling edge within a conversion restarts the read from bit 15 of the result present at that edge.
- R9: While convert and select are both low, the output enable is high and the data bit is 0.
- R10: A convert rising edge sampled while select is low does not select chip-select mode: for as long as convert stays high, the output is never enabled, whatever select does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| convert_i | input | 1 | Convert request; its rising edge starts a conversion |
| select_i | input | 1 | Select line, active low during a read |
| sclk_i | input | 1 | Serial clock from the host; falling edges shift |
| result_i | input | DATA_W | Parallel conversion result |
| sdata_o | output | 1 | Serial data bit |
| sdata_oe_o | output | 1 | High when the data pin is driven, low when released |

## Verification
The properties assume that convert, select and the serial clock are held for at least one system clock between changes, so that every edge is sampled once. They also assume that no convert edge is hidden inside a single sample period, and that inputs stay quiet during reset. The stimulus changes inputs only a quarter period after a rising clock edge and holds each level for at least one full cycle. It waits well beyond the conversion time before the normal reads, so the timing assumptions of the early-select checks hold. Over many result patterns, the stimulus drives full reads, aborted reads, reads that start too early, and conversions begun without chip-select mode.

// File: rtl/conv_serial_port.sv
module conv_serial_port #(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              convert_i,
  input  logic              select_i,
  input  logic              sclk_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              sdata_o,
  output logic              sdata_oe_o
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int TMR_W = $clog2(CONV_CYCLES + 1);

  logic              cnv_q, sel_q, sck_q;
  logic              cs_mode, done, active;
  logic [TMR_W-1:0]  tmr;
  logic [CNT_W-1:0]  bitcnt;
  logic [DATA_W-1:0] shreg;

  wire cnv_rise = convert_i & ~cnv_q;
  wire sel_fall = sel_q & ~select_i;
  wire sel_rise = ~sel_q & select_i;
  wire sck_fall = sck_q & ~sclk_i;
  wire drive    = active & convert_i & ~select_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnv_q <= 1'b1;
      sel_q <= 1'b0;
      sck_q <= 1'b0;
    end else begin
      cnv_q <= convert_i;
      sel_q <= select_i;
      sck_q <= sclk_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_mode <= 1'b0;
      done    <= 1'b0;
      tmr     <= '0;
    end else if (cnv_rise) begin
      cs_mode <= select_i;
      done    <= 1'b0;
      tmr     <= TMR_W'(CONV_CYCLES);
    end else if (tmr != '0) begin
      tmr <= tmr - 1'b1;
      if (tmr == TMR_W'(1)) done <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      bitcnt <= '0;
      shreg  <= '0;
    end else if (cnv_rise || !convert_i || sel_rise) begin
      active <= 1'b0;
    end else if (sel_fall && cs_mode && done) begin
      active <= 1'b1;
      bitcnt <= '0;
      shreg  <= result_i;
    end else if (active && sck_fall) begin
      if (bitcnt == CNT_W'(DATA_W - 1)) begin
        active <= 1'b0;
      end else begin
        bitcnt <= bitcnt + 1'b1;
        shreg  <= shreg << 1;
      end
    end
  end

  assign sdata_oe_o = drive | (~convert_i & ~select_i);
  assign sdata_o    = drive & shreg[DATA_W-1];

endmodule

// File: rtl/conv_serial_port_chk.sv
module conv_serial_port_chk #(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              convert_i,
  input logic              select_i,
  input logic              sclk_i,
  input logic [DATA_W-1:0] result_i,
  input logic              sdata_o,
  input logic              sdata_oe_o
);

  localparam int SR_W = $clog2(CONV_CYCLES + 2);
  localparam int FC_W = $clog2(DATA_W + 1);

  logic [1:0]      warm;
  logic [SR_W-1:0] since_rise;
  logic [FC_W-1:0] falls;
  wire             ok = warm[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      warm       <= '0;
      since_rise <= SR_W'(CONV_CYCLES + 1);
      falls      <= '0;
    end else begin
      warm <= {warm[0], 1'b1};
      if (warm[0] && convert_i && !$past(convert_i))
        since_rise <= SR_W'(1);
      else if (since_rise < SR_W'(CONV_CYCLES + 1))
        since_rise <= since_rise + 1'b1;
      if (!convert_i || select_i)
        falls <= '0;
      else if (warm[0] && !sclk_i && $past(sclk_i) && sdata_oe_o && falls < FC_W'(DATA_W))
        falls <= falls + 1'b1;
    end
  end

  a_r2_release_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    ok && $rose(convert_i) && select_i |=> (!convert_i || !sdata_oe_o));

  a_r3_no_early_drive: assert property (@(posedge clk) disable iff (!rst_n)
    ok && convert_i && since_rise <= SR_W'(CONV_CYCLES) |-> !sdata_oe_o);

  a_r6_release_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    convert_i && !select_i && falls == FC_W'(DATA_W) |-> !sdata_oe_o);

  a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !convert_i && !select_i |-> sdata_oe_o && !sdata_o);

  a_r5_hold_without_edges: assert property (@(posedge clk) disable iff (!rst_n)
    ok && $stable(convert_i) && $stable(select_i) && $stable(sclk_i)
    ##1 ($stable(convert_i) && $stable(select_i) && $stable(sclk_i))
    |-> $stable(sdata_o) && $stable(sdata_oe_o));

endmodule

bind conv_serial_port conv_serial_port_chk #(
  .DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)
) i_chk (
  .clk(clk), .rst_n(rst_n), .convert_i(convert_i), .select_i(select_i),
  .sclk_i(sclk_i), .result_i(result_i), .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o)
);

// File: tb/test_conv_serial_port.sv
`timescale 1ns/1ps
module test_conv_serial_port;
  localparam int W    = 16;
  localparam int CONV = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic convert_i = 1'b0, select_i = 1'b1, sclk_i = 1'b1;
  logic [W-1:0] result_i = '0;
  logic sdata_o, sdata_oe_o;
  int checks = 0, errors = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  conv_serial_port #(.DATA_W(W), .CONV_CYCLES(CONV)) i_conv_serial_port (
    .clk(clk), .rst_n(rst_n), .convert_i(convert_i), .select_i(select_i),
    .sclk_i(sclk_i), .result_i(result_i), .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o)
  );

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  task automatic check(input string req, input logic exp_oe, input logic exp_d);
    checks++;
    if (sdata_oe_o !== exp_oe || (exp_oe && sdata_o !== exp_d)) begin
      errors++;
      $display("FAIL %s: oe/data actual %b/%b expected %b/%b at %0t",
               req, sdata_oe_o, sdata_o, exp_oe, exp_d, $time);
    end
  endtask

  task automatic start_conv(input logic sel, input int wait_cyc);
    select_i  = sel;
    convert_i = 1'b1;
    repeat (wait_cyc) step();
  endtask

  task automatic end_conv();
    select_i  = 1'b1;
    convert_i = 1'b0;
    sclk_i    = 1'b1;
    step();
  endtask

  task automatic read_word(input logic [W-1:0] v, input int nfalls);
    result_i = v;
    select_i = 1'b0;
    step();
    check("R4 msb", 1'b1, v[W-1]);
    result_i = ~v;
    for (int i = 1; i <= nfalls; i++) begin
      sclk_i = 1'b1;
      step();
      check("R5 rise holds", 1'b1, v[W-i]);
      sclk_i = 1'b0;
      step();
      if (i < W) check("R5 shift", 1'b1, v[W-1-i]);
      else       check("R6 release", 1'b0, 1'b0);
    end
    sclk_i = 1'b1;
    step();
  endtask

  initial begin
    #2_000_000;
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] lfsr = 16'hACE1;
    logic [W-1:0] v;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    check("R1 reset", 1'b0, 1'b0);

    // R2: entry into chip-select mode releases the pin
    start_conv(1'b1, 1);
    check("R2 entry", 1'b0, 1'b0);
    repeat (CONV + 2) step();
    check("R2 idle after done", 1'b0, 1'b0);
    read_word(16'h8001, W);
    select_i = 1'b1; #1;
    check("R6 still released", 1'b0, 1'b0);
    end_conv();

    // Sweep: walking ones, walking zeros, pseudo-random words
    for (int k = 0; k < 64; k++) begin
      if (k < 16)      v = W'(1) << k;
      else if (k < 32) v = ~(W'(1) << (k - 16));
      else begin
        lfsr = {lfsr[W-2:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        v = lfsr;
      end
      start_conv(1'b1, CONV + 3);
      read_word(v, W);
      end_conv();
    end

    // R3: select low before completion is ignored, even when held past it
    start_conv(1'b1, 3);
    select_i = 1'b0;
    step();
    check("R3 early select", 1'b0, 1'b0);
    repeat (CONV + 3) step();
    check("R3 held low across done", 1'b0, 1'b0);
    select_i = 1'b1;
    step();
    read_word(16'h5A3C, W);
    end_conv();

    // R7 and R8: abort partway, then restart with a new result
    start_conv(1'b1, CONV + 3);
    read_word(16'hF00D, 5);
    select_i = 1'b1; #1;
    check("R7 select rise release", 1'b0, 1'b0);
    step();
    read_word(16'h1234, 3);
    select_i = 1'b1;
    step();
    read_word(16'hBEEF, W);
    end_conv();

    // R9: both low drives low
    select_i = 1'b0; #1;
    check("R9 idle low", 1'b1, 1'b0);
    step();
    check("R9 idle low held", 1'b1, 1'b0);

    // R10: convert rises with select low, no chip-select mode
    result_i = 16'hFFFF;
    start_conv(1'b0, 1);
    check("R10 no mode", 1'b0, 1'b0);
    repeat (CONV + 3) step();
    select_i = 1'b1;
    step();
    select_i = 1'b0;
    step();
    check("R10 select ignored", 1'b0, 1'b0);
    sclk_i = 1'b0;
    step();
    check("R10 sclk ignored", 1'b0, 1'b0);
    end_conv();
    check("R1 released again", 1'b0, 1'b0);

    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule